// File: doc/BRIEF.md
# Soft Reset and CPU Halt Controller

This block sits beside the host register port of a wireless MAC and drives two kinds of hold. The first is a soft reset. Setting one bit gates off every MAC and baseband clock domain and holds the MAC state machines in their initial state. The host-interface logic keeps its clock and keeps running, so the host can still read and write registers and can later release the hold. The bit does not clear itself. The device stays in soft reset until the host writes the bit back to zero. Entering or leaving soft reset starts no reload of stored configuration.

The second hold is a run/halt line for the embedded CPU. Its control bit is set to 1 to halt and cleared to 0 to run. On a hardware reset the bit takes the inverse of a boot-strap input. A low strap therefore leaves the CPU halted so the host can download code. A high strap lets the CPU start at once from its boot memory. The strap is only looked at while hardware reset is held.

Both controls are updated by a write on the register port and appear on the outputs right after the clock edge that samples the write.

Top module: `mac_hold_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the soft-reset bit clears to 0, every bit of `dom_clk_en` becomes 1, `fsm_rst` becomes 0, and `cpu_halt` takes the inverse of `boot_strap`.
- R2: The soft-reset control is bit 0 of the register at word address 0. Reads of that address return the bit in position 0 and zeros in bits 31:1, even after ones were written there.
- R3: After the clock edge that samples a write of 1 to bit 0 at address 0, every bit of `dom_clk_en` is 0 and `fsm_rst` is 1.
- R4: The soft-reset bit does not clear itself. It stays at 1 over idle cycles and returns to 0 only after the edge that samples a write of 0 to bit 0 at address 0. That edge brings `dom_clk_en` back to all ones and `fsm_rst` to 0.
- R5: The halt control is bit 0 of the register at word address 1. After the edge that samples a write there, `cpu_halt` equals the written bit 0 (1 = halted, 0 = running), and reading address 1 returns it in bit 0 with zeros above.
- R6: Outside hardware reset, changes of `boot_strap` have no effect on `cpu_halt` or on the halt readback.
- R7: The register port keeps working during soft reset. A soft-reset write leaves `cpu_halt` unchanged, and the halt register can be written and read while the soft reset is held.
- R8: A write to any word address other than 0 and 1 changes no output, and reads of such an address return 0.
- R9: With `reg_we` low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host-interface clock; never gated by this block |
| rst | input | 1 | Synchronous active-high hardware reset |
| boot_strap | input | 1 | Boot-strap pin; high = boot from flash, low = host download |
| reg_addr | input | 4 | Word address of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dom_clk_en | output | 4 | Clock enables, one per MAC/baseband domain; 0 while in soft reset |
| fsm_rst | output | 1 | Synchronous reset to MAC state machines; 1 while in soft reset |
| cpu_halt | output | 1 | Embedded CPU hold; 1 = halted, 0 = running |

## Verification
The soft-reset bit is set with all 32 data bits high. The test shows that only bit 0 takes effect and that the reserved bits read back as zero. It also shows that every domain enable drops together on the edge of the write. Idle stretches and strobe-low writes carrying a zero tell a level-held bit apart from a pulse or a self-clearing one. Writes to the halt register and to an unmapped address, made while the soft reset is held, show that the register path stays alive and that the two controls are separate. Two hardware resets with opposite strap levels, each followed by a strap toggle, show that the strap is captured only during reset.

// File: rtl/mac_hold_pkg.sv
package mac_hold_pkg;

    localparam int HOLD_DATA_W   = 32;
    localparam int HOLD_ADDR_W   = 4;
    localparam int HOLD_NUM_DOM  = 4;
    localparam int HOLD_SRST_IDX = 0;
    localparam int HOLD_HALT_IDX = 1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SRST = 2'd1,
        SEL_HALT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic wr_srst;
        logic wr_halt;
        logic wbit;
    } wr_req_t;

    function automatic reg_sel_e decode_sel(input int unsigned addr,
                                            input int unsigned srst_idx,
                                            input int unsigned halt_idx);
        if (addr == srst_idx)      return SEL_SRST;
        else if (addr == halt_idx) return SEL_HALT;
        else                       return SEL_NONE;
    endfunction

endpackage

// File: rtl/mac_hold_dec.sv
module mac_hold_dec
    import mac_hold_pkg::*;
#(
    parameter int ADDR_W   = HOLD_ADDR_W,
    parameter int DATA_W   = HOLD_DATA_W,
    parameter int SRST_IDX = HOLD_SRST_IDX,
    parameter int HALT_IDX = HOLD_HALT_IDX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wbit,
    input  logic              srst_bit,
    input  logic              halt_bit,
    output wr_req_t           req,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e sel;

    always_comb begin
        sel         = decode_sel(int'(addr), SRST_IDX, HALT_IDX);
        req.wr_srst = we && (sel == SEL_SRST);
        req.wr_halt = we && (sel == SEL_HALT);
        req.wbit    = wbit;
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_SRST: rdata[0] = srst_bit;
            SEL_HALT: rdata[0] = halt_bit;
            default:  rdata    = '0;
        endcase
    end

    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req.wr_srst, req.wr_halt}));

    // R9
    idle_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !we |-> !(req.wr_srst || req.wr_halt));

endmodule

// File: rtl/mac_hold_halt.sv
module mac_hold_halt (
    input  logic clk,
    input  logic rst,
    input  logic boot_strap,
    input  logic wr,
    input  logic wbit,
    output logic halt
);

    always_ff @(posedge clk) begin
        if (rst)     halt <= ~boot_strap;
        else if (wr) halt <= wbit;
    end

    // R5
    halt_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (halt == $past(wbit)));

    // R6
    strap_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(halt));

endmodule

// File: rtl/mac_hold_srst.sv
module mac_hold_srst #(
    parameter int NUM_DOM = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               wbit,
    output logic               srst_bit,
    output logic               fsm_rst,
    output logic [NUM_DOM-1:0] dom_clk_en
);

    logic srst_d;

    assign srst_d = wr ? wbit : srst_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_bit <= 1'b0;
            fsm_rst  <= 1'b0;
        end else begin
            srst_bit <= srst_d;
            fsm_rst  <= srst_d;
        end
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        always_ff @(posedge clk) begin
            if (rst) dom_clk_en[d] <= 1'b1;
            else     dom_clk_en[d] <= ~srst_d;
        end
    end

    // R3
    enter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && wbit) |=> (fsm_rst && (dom_clk_en == '0)));

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr && fsm_rst) |=> (fsm_rst && (dom_clk_en == '0)));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !wbit) |=> (!fsm_rst && (dom_clk_en == '1)));

endmodule

// File: rtl/mac_hold_ctrl.sv
module mac_hold_ctrl
    import mac_hold_pkg::*;
#(
    parameter int ADDR_W   = HOLD_ADDR_W,
    parameter int DATA_W   = HOLD_DATA_W,
    parameter int NUM_DOM  = HOLD_NUM_DOM,
    parameter int SRST_IDX = HOLD_SRST_IDX,
    parameter int HALT_IDX = HOLD_HALT_IDX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boot_strap,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_DOM-1:0] dom_clk_en,
    output logic               fsm_rst,
    output logic               cpu_halt
);

    wr_req_t req;
    logic    srst_bit;
    logic    unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:1];

    mac_hold_dec #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SRST_IDX(SRST_IDX),
        .HALT_IDX(HALT_IDX)
    ) dec_i (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .we      (reg_we),
        .wbit    (reg_wdata[0]),
        .srst_bit(srst_bit),
        .halt_bit(cpu_halt),
        .req     (req),
        .rdata   (reg_rdata)
    );

    mac_hold_srst #(
        .NUM_DOM(NUM_DOM)
    ) srst_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (req.wr_srst),
        .wbit      (req.wbit),
        .srst_bit  (srst_bit),
        .fsm_rst   (fsm_rst),
        .dom_clk_en(dom_clk_en)
    );

    mac_hold_halt halt_i (
        .clk       (clk),
        .rst       (rst),
        .boot_strap(boot_strap),
        .wr        (req.wr_halt),
        .wbit      (req.wbit),
        .halt      (cpu_halt)
    );

    // R7
    halt_apart_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (int'(reg_addr) == SRST_IDX)) |=> $stable(cpu_halt));

endmodule

// File: tb/mac_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module mac_hold_ctrl_tb_top;

    localparam int AW = 4;
    localparam int DW = 32;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boot_strap = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [ND-1:0] dom_clk_en;
    logic          fsm_rst;
    logic          cpu_halt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string         tag;
        logic          halt;
        logic          srst;
        logic [DW-1:0] rdata;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #2.5 clk = ~clk;

    mac_hold_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .boot_strap(boot_strap),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dom_clk_en(dom_clk_en),
        .fsm_rst   (fsm_rst),
        .cpu_halt  (cpu_halt)
    );

    // Monitor: compares outputs at the falling edge after each driven edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if (cpu_halt !== cur.halt || fsm_rst !== cur.srst ||
                dom_clk_en !== {ND{~cur.srst}} || reg_rdata !== cur.rdata) begin
                errors++;
                $display("FAIL %s: halt=%b fsm_rst=%b en=%b rdata=%h expected halt=%b fsm_rst=%b en=%b rdata=%h",
                         cur.tag, cpu_halt, fsm_rst, dom_clk_en, reg_rdata,
                         cur.halt, cur.srst, {ND{~cur.srst}}, cur.rdata);
            end
        end
    end

    task automatic push_exp(input string tag, input logic eh, input logic es,
                            input logic [DW-1:0] erd);
        exp_t e;
        e.tag = tag; e.halt = eh; e.srst = es; e.rdata = erd;
        exp_q.push_back(e);
    endtask

    // Driver: one register-port cycle, then the expected state after its edge
    task automatic step(input logic we, input logic [AW-1:0] addr,
                        input logic [DW-1:0] data, input string tag,
                        input logic eh, input logic es, input logic [DW-1:0] erd);
        @(negedge clk); #1;
        reg_we = we; reg_addr = addr; reg_wdata = data;
        @(posedge clk);
        push_exp(tag, eh, es, erd);
    endtask

    task automatic hw_reset(input logic strap, input logic [AW-1:0] addr,
                            input string tag, input logic eh);
        @(negedge clk); #1;
        rst = 1'b1; reg_we = 1'b0; boot_strap = strap; reg_addr = addr;
        @(posedge clk);
        @(posedge clk);
        push_exp(tag, eh, 1'b0, (addr == 4'd1) ? {31'b0, eh} : '0);
        @(negedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic set_strap(input logic v);
        @(negedge clk); #1;
        boot_strap = v;
    endtask

    initial begin
        // R1: reset with high strap -> running, no soft reset
        hw_reset(1'b1, 4'd0, "R1 reset strap high", 1'b0);
        step(1'b0, 4'd1, 32'h0, "R5 halt readback after reset", 1'b0, 1'b0, 32'h0);
        // R6: strap toggles after reset are ignored
        set_strap(1'b0);
        step(1'b0, 4'd1, 32'h0, "R6 strap low ignored", 1'b0, 1'b0, 32'h0);
        step(1'b0, 4'd1, 32'h0, "R6 strap low ignored later", 1'b0, 1'b0, 32'h0);
        // R3 / R2: enter soft reset with all data bits set
        step(1'b1, 4'd0, 32'hFFFF_FFFF, "R3 enter soft reset", 1'b0, 1'b1, 32'h1);
        step(1'b0, 4'd0, 32'hFFFF_FFFF, "R2 reserved bits read zero", 1'b0, 1'b1, 32'h1);
        // R4: level-held over idle cycles
        for (int i = 0; i < 5; i++)
            step(1'b0, 4'd0, 32'h0, "R4 hold over idle", 1'b0, 1'b1, 32'h1);
        // R7: halt register usable during soft reset
        step(1'b1, 4'd1, 32'h0000_0001, "R7 halt write in soft reset", 1'b1, 1'b1, 32'h1);
        step(1'b0, 4'd1, 32'h0, "R7 halt readback in soft reset", 1'b1, 1'b1, 32'h1);
        // R9: strobe low with zero data on the soft-reset register
        step(1'b0, 4'd0, 32'h0, "R9 no write without strobe", 1'b1, 1'b1, 32'h1);
        step(1'b0, 4'd1, 32'h0, "R9 halt unchanged without strobe", 1'b1, 1'b1, 32'h1);
        // R8: unmapped writes
        step(1'b1, 4'd5, 32'h0, "R8 unmapped write zero", 1'b1, 1'b1, 32'h0);
        step(1'b1, 4'd15, 32'hFFFF_FFFF, "R8 unmapped write ones", 1'b1, 1'b1, 32'h0);
        step(1'b0, 4'd0, 32'h0, "R8 soft reset kept", 1'b1, 1'b1, 32'h1);
        // R4: release by writing 0; R7 halt kept
        step(1'b1, 4'd0, 32'h0, "R4 release soft reset", 1'b1, 1'b0, 32'h0);
        step(1'b0, 4'd1, 32'h0, "R7 halt kept after release", 1'b1, 1'b0, 32'h1);
        // R5: run the CPU, reserved halt bits read zero
        step(1'b1, 4'd1, 32'hFFFF_FFFE, "R5 halt write run", 1'b0, 1'b0, 32'h0);
        step(1'b1, 4'd1, 32'h8000_0001, "R5 halt write halt", 1'b1, 1'b0, 32'h1);
        step(1'b1, 4'd1, 32'h0, "R5 halt write run again", 1'b0, 1'b0, 32'h0);
        // R1: soft reset set, then hardware reset with low strap
        step(1'b1, 4'd0, 32'h1, "R3 enter soft reset again", 1'b0, 1'b1, 32'h1);
        hw_reset(1'b0, 4'd0, "R1 reset clears soft reset", 1'b1);
        step(1'b0, 4'd1, 32'h0, "R1 strap low halts", 1'b1, 1'b0, 32'h1);
        // R6: strap high after reset ignored
        set_strap(1'b1);
        step(1'b0, 4'd1, 32'h0, "R6 strap high ignored", 1'b1, 1'b0, 32'h1);
        step(1'b0, 4'd0, 32'h0, "R6 soft reset still clear", 1'b1, 1'b0, 32'h0);
        @(negedge clk); #1;
        reg_we = 1'b0;
        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL queue drain: %0d left expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule